// File: doc/BRIEF.md
# Asynchronous Host Register-File Interface

This block lets an external microcontroller exchange control words and handshake flags with logic inside the FPGA. The host has no clock of its own on this link. It presents a 4-bit register address and a 16-bit data word, and pulses an active-low read strobe or an active-low write strobe. The block brings both strobes into the system clock domain through two-flop synchronizers. It captures the address and write data while the synchronized write strobe is low. The write takes effect once, when the synchronized strobe rises.

The 16-entry register space holds three kinds of register. Address 0 is a flag register that combines live status inputs with sticky mailbox bits: internal logic sets a mailbox bit with a one-cycle pulse, and the host clears it by writing a 1 to that bit. A bank of read/write control registers follows it, and their values drive the fabric directly. All remaining addresses are unmapped. The data bus is driven only while a synchronized read is in progress. The tri-state buffer sits outside the block and is controlled by an output-enable pin.

Top module: `hostreg_if`

## Requirements
- R1: After reset, every control register and every mailbox bit is 0 and the output enable is low.
- R2: A host write to a control address (1 to NUM_CTRL, default 1..4) loads the 16-bit data into that register. The new value appears on ctrl_regs within 3 clock cycles of the write strobe rising, and each strobe commits exactly once.
- R3: While the read strobe is low, after two synchronizing cycles, host_oe is 1 and host_rdata carries the addressed register. host_oe returns to 0 within 2 cycles of the read strobe rising.
- R4: The flag register at address 0 reads the mailbox bits in bits [NMBX-1:0] (default [7:0]) and status_in in the next NSTAT bits (default [15:8]), with any higher bits 0. Status bits cannot be changed by a write.
- R5: A 1 on mbox_set[i] for one cycle sets mailbox bit i, and the bit stays set until the host clears it.
- R6: A host write to address 0 clears every mailbox bit whose data bit is 1 and leaves the other mailbox bits unchanged. Mailbox bits change at no other time.
- R7: If a set pulse and a host clear hit the same mailbox bit in the same cycle, the bit stays set.
- R8: Reads from unmapped addresses (default 5..15) return 0. Writes to them change no control register and no mailbox bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rd_n | input | 1 | Asynchronous read strobe, active low |
| host_wr_n | input | 1 | Asynchronous write strobe, active low |
| host_rdata | output | 16 | Read data, valid while host_oe is 1, otherwise 0 |
| host_oe | output | 1 | Enable for the external data-bus driver |
| status_in | input | NSTAT | Live status bits shown in the flag register |
| mbox_set | input | NMBX | One-cycle set pulses for the mailbox bits |
| mbox_flags | output | NMBX | Current mailbox bits |
| ctrl_regs | output | NUM_CTRL*16 | Control registers, register k in bits [16k+15:16k] |

## Verification
A wrong capture or commit in the write path shows on ctrl_regs no more than three cycles after the strobe rises: a register holds the wrong word, or a neighbouring register or an unmapped write changes something it should not. A mailbox bit in the wrong state shows at once on mbox_flags and on the next flag-register read. A lost set pulse during a host clear shows as a 0 the cycle after the collision. A mistimed synchronizer shows as host_oe asserting without a read strobe, or staying on after the strobe is released.

// File: rtl/hostreg_pkg.sv
// Shared constants for the host register interface: bus widths and the
// fixed positions in the register map that the read and write paths decode.
package hostreg_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] FLAG_ADDR = 4'd0;
    localparam int CTRL_BASE = 1;
endpackage

// File: rtl/hostreg_sync.sv
// Two-flop synchronizer for a bundle of independent asynchronous levels.
// Assumes each bit is a level held for several clock cycles, and that no
// bundle of bits must be sampled together coherently.
module hostreg_sync #(
    parameter int W = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    // Two-stage capture of the asynchronous levels into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= RST_VAL;
            stable_q <= RST_VAL;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;
endmodule

// File: rtl/hostreg_flags.sv
// Mailbox bits of the flag register. Internal set pulses make a bit sticky,
// and a host write clears the bits it marks with a 1. A set pulse wins over
// a clear in the same cycle, so no event is lost.
module hostreg_flags #(
    parameter int NMBX = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NMBX-1:0] set_pulse,
    input  logic            clr_we,
    input  logic [NMBX-1:0] clr_mask,
    output logic [NMBX-1:0] flags
);
    logic [NMBX-1:0] flags_q;
    logic [NMBX-1:0] clr_eff;

    // Apply the clear mask only in the cycle of a flag-register commit.
    always_comb clr_eff = clr_we ? clr_mask : '0;

    // Each bit is cleared by write-one, then set by a pulse; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_eff) | set_pulse;
    end

    assign flags = flags_q;
endmodule

// File: rtl/hostreg_ctrl.sv
// Bank of host-writable control registers at consecutive addresses starting
// at CTRL_BASE. Each register loads on a commit to its own address.
module hostreg_ctrl
    import hostreg_pkg::*;
#(
    parameter int NUM_CTRL = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  logic [ADDR_W-1:0]          waddr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NUM_CTRL*DATA_W-1:0] regs
);
    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CTRL_BASE + i);
        logic [DATA_W-1:0] val_q;

        // Load this register when a commit targets its address.
        always_ff @(posedge clk) begin
            if (!rst_n)                           val_q <= '0;
            else if (commit && waddr == MY_ADDR)  val_q <= wdata;
        end

        assign regs[i*DATA_W +: DATA_W] = val_q;
    end
endmodule

// File: rtl/hostreg_if.sv
// Register-file slave for an asynchronous host bus with active-low read and
// write strobes. Assumes the host holds address and data stable for the
// whole strobe-low period and keeps each strobe low for at least three
// clock cycles. Writes commit on the synchronized rising edge of the write
// strobe. Read data is registered and qualified by host_oe.
module hostreg_if
    import hostreg_pkg::*;
#(
    parameter int NUM_CTRL = 4,
    parameter int NMBX     = 8,
    parameter int NSTAT    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [DATA_W-1:0]          host_wdata,
    input  logic                       host_rd_n,
    input  logic                       host_wr_n,
    output logic [DATA_W-1:0]          host_rdata,
    output logic                       host_oe,
    input  logic [NSTAT-1:0]           status_in,
    input  logic [NMBX-1:0]            mbox_set,
    output logic [NMBX-1:0]            mbox_flags,
    output logic [NUM_CTRL*DATA_W-1:0] ctrl_regs
);
    localparam int FLAG_BITS = NMBX + NSTAT;

    logic [1:0]        strobe_sync;
    logic              rd_n_s;
    logic              wr_n_s;
    logic              wr_n_prev;
    logic              wr_commit;
    logic [ADDR_W-1:0] waddr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [ADDR_W-1:0] raddr_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] flag_word;

    hostreg_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({host_rd_n, host_wr_n}),
        .sync_out (strobe_sync)
    );
    assign rd_n_s = strobe_sync[1];
    assign wr_n_s = strobe_sync[0];

    // Remember the previous synchronized write level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_n_prev <= 1'b1;
        else        wr_n_prev <= wr_n_s;
    end

    assign wr_commit = wr_n_s && !wr_n_prev;

    // Sample write address and data while the synchronized strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr_q <= '0;
            wdata_q <= '0;
        end else if (!wr_n_s) begin
            waddr_q <= host_addr;
            wdata_q <= host_wdata;
        end
    end

    hostreg_flags #(.NMBX(NMBX)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (mbox_set),
        .clr_we    (wr_commit && waddr_q == FLAG_ADDR),
        .clr_mask  (wdata_q[NMBX-1:0]),
        .flags     (mbox_flags)
    );

    hostreg_ctrl #(.NUM_CTRL(NUM_CTRL)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (wr_commit),
        .waddr  (waddr_q),
        .wdata  (wdata_q),
        .regs   (ctrl_regs)
    );

    // Assemble the flag register: mailbox low, status above, zero beyond.
    always_comb begin
        flag_word                = '0;
        flag_word[NMBX-1:0]      = mbox_flags;
        flag_word[NMBX +: NSTAT] = status_in;
    end

    // Register the host address for the read path.
    always_ff @(posedge clk) begin
        if (!rst_n) raddr_q <= '0;
        else        raddr_q <= host_addr;
    end

    // Select the addressed register; unmapped addresses read as zero.
    always_comb begin
        rd_mux = '0;
        if (raddr_q == FLAG_ADDR) rd_mux = flag_word;
        for (int k = 0; k < NUM_CTRL; k++) begin
            if (raddr_q == ADDR_W'(CTRL_BASE + k))
                rd_mux = ctrl_regs[k*DATA_W +: DATA_W];
        end
    end

    // Hold the selected word in a register that drives the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_mux;
    end

    assign host_oe    = !rd_n_s;
    assign host_rdata = host_oe ? rdata_q : '0;

    if (FLAG_BITS > DATA_W) begin : g_bad_cfg
        initial $error("mailbox and status bits exceed the data width");
    end
endmodule

// File: rtl/hostreg_if_chk.sv
// Protocol checker for hostreg_if, attached by bind. It observes the ports
// and the internal write-commit pulse.
module hostreg_if_chk #(
    parameter int NUM_CTRL = 4,
    parameter int NMBX     = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     host_rd_n,
    input logic                     host_oe,
    input logic [NMBX-1:0]          mbox_set,
    input logic [NMBX-1:0]          mbox_flags,
    input logic [NUM_CTRL*16-1:0]   ctrl_regs,
    input logic                     commit
);
    // R2: control registers change only on a commit.
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(ctrl_regs));

    // R2: one commit per strobe edge, never two in a row.
    p_commit_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R3: the bus is enabled only after the read strobe has been low.
    p_oe_needs_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_oe |-> !$past(host_rd_n, 2));

    // R5 and R7: a set pulse always leaves its bit set.
    p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|mbox_set) |=> ((mbox_flags & $past(mbox_set)) == $past(mbox_set)));

    // R6: without a commit, no mailbox bit falls.
    p_no_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ((~mbox_flags & $past(mbox_flags)) == '0));

    // R6: a mailbox bit rises only through a set pulse.
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mbox_flags & ~$past(mbox_flags) & ~$past(mbox_set)) == '0));
endmodule

bind hostreg_if hostreg_if_chk #(.NUM_CTRL(NUM_CTRL), .NMBX(NMBX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_rd_n  (host_rd_n),
    .host_oe    (host_oe),
    .mbox_set   (mbox_set),
    .mbox_flags (mbox_flags),
    .ctrl_regs  (ctrl_regs),
    .commit     (wr_commit)
);

// File: tb/hostreg_if_bench.sv
`timescale 1ns/1ps
module hostreg_if_bench;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    host_addr = '0;
    logic [15:0]   host_wdata = '0;
    logic          host_rd_n = 1'b1;
    logic          host_wr_n = 1'b1;
    logic [15:0]   host_rdata;
    logic          host_oe;
    logic [7:0]    status_in = 8'hA6;
    logic [7:0]    mbox_set = '0;
    logic [7:0]    mbox_flags;
    logic [NC*16-1:0] ctrl_regs;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_ctrl [NC];
    logic [7:0]  exp_mbox = '0;

    hostreg_if u_hostreg_if (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_rdata(host_rdata),
        .host_oe(host_oe), .status_in(status_in), .mbox_set(mbox_set),
        .mbox_flags(mbox_flags), .ctrl_regs(ctrl_regs)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Expected read value of any address, from the register map.
    function automatic logic [15:0] exp_read(input int a);
        if (a == 0) return {status_in, exp_mbox};
        if (a >= 1 && a <= NC) return exp_ctrl[a-1];
        return 16'h0000;
    endfunction

    function automatic logic [NC*16-1:0] exp_ctrl_flat();
        logic [NC*16-1:0] v;
        for (int k = 0; k < NC; k++) v[k*16 +: 16] = exp_ctrl[k];
        return v;
    endfunction

    task automatic host_write(input int a, input logic [15:0] d);
        @(negedge clk);
        host_addr = 4'(a); host_wdata = d; host_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (3) @(negedge clk);
        if (a == 0) exp_mbox = exp_mbox & ~d[7:0];
        else if (a <= NC) exp_ctrl[a-1] = d;
        // R2: value visible three cycles after the strobe rises
        check("R2 ctrl after write", 64'(ctrl_regs), 64'(exp_ctrl_flat()));
        check("R6 mailbox after write", 64'(mbox_flags), 64'(exp_mbox));
    endtask

    task automatic host_read(input int a, input string req);
        @(negedge clk);
        host_addr = 4'(a); host_rd_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R3 oe during read", 64'(host_oe), 64'd1);
        check(req, 64'(host_rdata), 64'(exp_read(a)));
        host_rd_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R3 oe released", 64'(host_oe), 64'd0);
    endtask

    function automatic logic [15:0] pat(input int p, input int a);
        return 16'(16'h1357 * (p + 1)) ^ {4{4'(a)}};
    endfunction

    initial begin
        for (int k = 0; k < NC; k++) exp_ctrl[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 ctrl reset", 64'(ctrl_regs), 64'd0);
        check("R1 mailbox reset", 64'(mbox_flags), 64'd0);
        check("R1 oe reset", 64'(host_oe), 64'd0);
        // R4: flag layout with status only
        host_read(0, "R4 flag read after reset");

        // R2, R3, R8: sweep writes and reads of all addresses under patterns
        for (int p = 0; p < 3; p++) begin
            @(negedge clk); mbox_set = 8'hFF; @(negedge clk); mbox_set = '0;
            exp_mbox = 8'hFF;
            status_in = 8'(8'h3C + p * 8'h51);
            for (int a = 0; a < 16; a++) host_write(a, pat(p, a));
            for (int a = 0; a < 16; a++)
                host_read(a, (a > NC) ? "R8 unmapped read" : "R3 read data");
        end

        // R5: set pulses are sticky
        host_write(0, 16'h00FF);
        @(negedge clk); mbox_set = 8'h5A; @(negedge clk); mbox_set = '0;
        exp_mbox = 8'h5A;
        repeat (3) @(negedge clk);
        check("R5 mailbox sticky", 64'(mbox_flags), 64'(exp_mbox));
        host_read(0, "R4 flag with mailbox");

        // R6: write-one-to-clear of bits 1 and 4 only
        host_write(0, 16'hFF12);
        check("R6 partial clear", 64'(mbox_flags), 64'h48);
        // R4: status bits unaffected by the write
        host_read(0, "R4 status read-only");

        // R8: unmapped writes leave everything unchanged
        for (int a = NC + 1; a < 16; a++) host_write(a, 16'hFFFF);
        check("R8 unmapped no effect", 64'(mbox_flags), 64'h48);

        // R7: set pulse collides with a clear of the same bit
        @(negedge clk);
        host_addr = 4'd0; host_wdata = 16'h0048; host_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        host_wr_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        mbox_set = 8'h08;
        @(negedge clk);
        mbox_set = '0;
        @(negedge clk);
        check("R7 set beats clear", 64'(mbox_flags), 64'h08);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule